// File: doc/BRIEF.md
# Mode-Register Write Timing Guard

This block stands between a memory controller's command scheduler and the DRAM command bus. The scheduler offers one command at a time over a valid/ready handshake. The guard lowers ready while a DRAM timing rule forbids that command. An accepted command is registered onto the DRAM-side outputs. An attempt made while ready is low is dropped, and it raises a sticky violation flag with a cause code.

Writes to the four mode registers are the only commands that start timers. Each write starts a short spacing window for further mode writes, a longer update window for ordinary commands, and a hold window that keeps clock enable high. A write that alters the CAS-latency field starts a longer settle window. A write that sets the DLL-reset bit starts a lock window. No-op and deselect are never held back. The block also keeps a shadow of every register value written. The DLL-reset bit in the shadow clears itself.

Top module: `mrs_guard`

## Requirements
- R1: Command codes are 0 no-op, 1 deselect, 2 mode-register write, 3 activate, 4 read, 5 write, 6 precharge, 7 refresh. A command accepted in cycle T (cmd_valid and cmd_ready both high) appears on out_valid/out_code/out_sel/out_val in cycle T+1. out_valid is low in any cycle after which no command was accepted.
- R2: A mode-register write (code 2) is ready only when banks_idle and prech_met are high and burst_busy is low. Codes 0, 1 and 3 to 7 do not depend on these three inputs.
- R3: After a mode-register write accepted in cycle T, the next mode-register write is ready no earlier than cycle T+TMRD. Ready for it stays low for exactly TMRD-1 cycles (default 4).
- R4: After a mode-register write accepted in cycle T, codes 3 to 7 are not ready before cycle T+TMOD (default 12). Codes 0 and 1 are always ready.
- R5: A mode-register write replaces all 14 bits of the selected register. Register n is shown at mr_shadow[14n+13:14n] from cycle T+1.
- R6: Bit 8 of register 0 reads 1 in cycle T+1 after a write that sets it, and it reads 0 from cycle T+2 on. All other bits hold their value until they are rewritten.
- R7: The synchronous active-high reset clears all four shadow registers, every timer, out_valid, viol and viol_cause.
- R8: cke is high in the cycle of a mode-register write and for TMRSPDEN-1 cycles after it (default 10), even when pd_req is high. Outside that window, cke equals the inverse of pd_req.
- R9: A write to register 0 that changes its CAS-latency field (bits 6:4 and bit 2) keeps codes 3 to 7 not ready until cycle T+TXPDLL (default 24).
- R10: A write to register 0 with bit 8 set keeps codes 3 to 7 not ready until cycle T+TDLLK (default 512).
- R11: A command presented with cmd_valid high while cmd_ready is low is dropped, and it sets viol, which stays set until reset. viol_cause keeps the cause of the first such attempt. For a mode-register write the cause is 1 (spacing window), else 2 (banks not idle), else 3 (precharge not met), else 4 (burst busy). For codes 3 to 7 the cause is 7 (DLL lock window), else 6 (latency window), else 5 (update window).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Scheduler offers a command |
| cmd_ready | output | 1 | Offered command may issue this cycle |
| cmd_code | input | 3 | Command code |
| cmd_sel | input | 2 | Mode register index |
| cmd_val | input | 14 | Full register value for a mode write |
| banks_idle | input | 1 | All banks idle and precharged |
| prech_met | input | 1 | Row-precharge time has elapsed |
| burst_busy | input | 1 | A data burst is in progress |
| pd_req | input | 1 | Power-down request |
| cke | output | 1 | Clock enable to the DRAM |
| out_valid | output | 1 | DRAM bus command valid |
| out_code | output | 3 | DRAM bus command code |
| out_sel | output | 2 | DRAM bus register index |
| out_val | output | 14 | DRAM bus address value |
| mr_shadow | output | 56 | Shadow copy of the four registers |
| viol | output | 1 | Sticky violation flag |
| viol_cause | output | 3 | Cause of the first violation |

## Verification
cmd_ready and cke are combinational, so the bench reads them within the cycle, just after the falling edge, once it has set the probed code. Bus outputs, shadow contents and the violation state are registered once, so each is read one cycle after the accepting edge. The bit-8 self-clear is read at both T+1 and T+2. Each window is measured by counting low-ready cycles from T+1, which must give TMRD-1, TMOD-1 or TXPDLL-1. The DLL count starts at T+2 and must give TDLLK-2.

// File: rtl/mrs_guard_pkg.sv
package mrs_guard_pkg;

    localparam int FIELD_W     = 14;
    localparam int SEL_W       = 2;
    localparam int NUM_MR      = 1 << SEL_W;
    localparam int CODE_W      = 3;
    localparam int DLL_RST_BIT = 8;
    localparam int CL_W        = 4;

    typedef enum logic [CODE_W-1:0] {
        CMD_NOP = 3'd0,
        CMD_DES = 3'd1,
        CMD_MRS = 3'd2,
        CMD_ACT = 3'd3,
        CMD_RD  = 3'd4,
        CMD_WR  = 3'd5,
        CMD_PRE = 3'd6,
        CMD_REF = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_SPACING = 3'd1,
        CAUSE_BANKS   = 3'd2,
        CAUSE_PRECH   = 3'd3,
        CAUSE_BURST   = 3'd4,
        CAUSE_UPDATE  = 3'd5,
        CAUSE_LATENCY = 3'd6,
        CAUSE_DLL     = 3'd7
    } cause_e;

    typedef struct packed {
        cmd_e               code;
        logic [SEL_W-1:0]   sel;
        logic [FIELD_W-1:0] val;
    } cmd_t;

    typedef struct packed {
        logic mrd;
        logic upd;
        logic lat;
        logic dll;
        logic pdh;
    } busy_t;

    function automatic logic is_filler(input cmd_e c);
        return (c == CMD_NOP) || (c == CMD_DES);
    endfunction

    function automatic logic [CL_W-1:0] cl_bits(input logic [FIELD_W-1:0] v);
        return {v[6:4], v[2]};
    endfunction

endpackage

// File: rtl/mrs_wait_ctr.sv
module mrs_wait_ctr #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] RELOAD = W'(CYCLES - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= RELOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/mrs_shadow.sv
module mrs_shadow
    import mrs_guard_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [SEL_W-1:0]          wsel,
    input  logic [FIELD_W-1:0]        wval,
    output logic [NUM_MR*FIELD_W-1:0] regs_flat,
    output logic                      cl_change,
    output logic                      dll_set
);
    genvar i;
    generate
        for (i = 0; i < NUM_MR; i++) begin : g_mr
            logic [FIELD_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we && (wsel == SEL_W'(i))) begin
                    q <= wval;
                end else if (i == 0) begin
                    q[DLL_RST_BIT] <= 1'b0;
                end
            end
            assign regs_flat[i*FIELD_W +: FIELD_W] = q;
        end
    endgenerate

    logic wr0;
    assign wr0       = we && (wsel == '0);
    assign cl_change = wr0 && (cl_bits(wval) != cl_bits(regs_flat[FIELD_W-1:0]));
    assign dll_set   = wr0 && wval[DLL_RST_BIT];
endmodule

// File: rtl/mrs_admit.sv
module mrs_admit
    import mrs_guard_pkg::*;
(
    input  cmd_e   code,
    input  logic   banks_idle,
    input  logic   prech_met,
    input  logic   burst_busy,
    input  busy_t  busy,
    output logic   ready,
    output cause_e cause
);
    always_comb begin
        cause = CAUSE_NONE;
        if (code == CMD_MRS) begin
            if (busy.mrd)         cause = CAUSE_SPACING;
            else if (!banks_idle) cause = CAUSE_BANKS;
            else if (!prech_met)  cause = CAUSE_PRECH;
            else if (burst_busy)  cause = CAUSE_BURST;
        end else if (!is_filler(code)) begin
            if (busy.dll)         cause = CAUSE_DLL;
            else if (busy.lat)    cause = CAUSE_LATENCY;
            else if (busy.upd)    cause = CAUSE_UPDATE;
        end
        ready = (cause == CAUSE_NONE);
    end
endmodule

// File: rtl/mrs_guard.sv
module mrs_guard
    import mrs_guard_pkg::*;
#(
    parameter int TMRD     = 4,
    parameter int TMOD     = 12,
    parameter int TMRSPDEN = 10,
    parameter int TXPDLL   = 24,
    parameter int TDLLK    = 512
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_valid,
    output logic                      cmd_ready,
    input  logic [CODE_W-1:0]         cmd_code,
    input  logic [SEL_W-1:0]          cmd_sel,
    input  logic [FIELD_W-1:0]        cmd_val,
    input  logic                      banks_idle,
    input  logic                      prech_met,
    input  logic                      burst_busy,
    input  logic                      pd_req,
    output logic                      cke,
    output logic                      out_valid,
    output logic [CODE_W-1:0]         out_code,
    output logic [SEL_W-1:0]          out_sel,
    output logic [FIELD_W-1:0]        out_val,
    output logic [NUM_MR*FIELD_W-1:0] mr_shadow,
    output logic                      viol,
    output logic [2:0]                viol_cause
);
    cmd_t   in_cmd;
    busy_t  busy;
    cause_e cause;
    logic   fire, mrs_fire, cl_change, dll_set;
    cmd_t   out_q;
    logic   out_v_q;
    logic   viol_q;
    cause_e cause_q;

    assign in_cmd.code = cmd_e'(cmd_code);
    assign in_cmd.sel  = cmd_sel;
    assign in_cmd.val  = cmd_val;

    mrs_admit u_admit (
        .code       (in_cmd.code),
        .banks_idle (banks_idle),
        .prech_met  (prech_met),
        .burst_busy (burst_busy),
        .busy       (busy),
        .ready      (cmd_ready),
        .cause      (cause)
    );

    assign fire     = cmd_valid && cmd_ready;
    assign mrs_fire = fire && (in_cmd.code == CMD_MRS);

    mrs_wait_ctr #(.CYCLES(TMRD))     u_mrd (.clk(clk), .rst(rst), .load(mrs_fire),  .busy(busy.mrd));
    mrs_wait_ctr #(.CYCLES(TMOD))     u_upd (.clk(clk), .rst(rst), .load(mrs_fire),  .busy(busy.upd));
    mrs_wait_ctr #(.CYCLES(TMRSPDEN)) u_pdh (.clk(clk), .rst(rst), .load(mrs_fire),  .busy(busy.pdh));
    mrs_wait_ctr #(.CYCLES(TXPDLL))   u_lat (.clk(clk), .rst(rst), .load(cl_change), .busy(busy.lat));
    mrs_wait_ctr #(.CYCLES(TDLLK))    u_dll (.clk(clk), .rst(rst), .load(dll_set),   .busy(busy.dll));

    mrs_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .we        (mrs_fire),
        .wsel      (in_cmd.sel),
        .wval      (in_cmd.val),
        .regs_flat (mr_shadow),
        .cl_change (cl_change),
        .dll_set   (dll_set)
    );

    assign cke = !(pd_req && !busy.pdh && !mrs_fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v_q <= 1'b0;
            out_q   <= '0;
            viol_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            out_v_q <= fire;
            if (fire) out_q <= in_cmd;
            if (cmd_valid && !cmd_ready) begin
                viol_q <= 1'b1;
                if (!viol_q) cause_q <= cause;
            end
        end
    end

    assign out_valid  = out_v_q;
    assign out_code   = out_q.code;
    assign out_sel    = out_q.sel;
    assign out_val    = out_q.val;
    assign viol       = viol_q;
    assign viol_cause = cause_q;
endmodule

// File: rtl/mrs_guard_chk.sv
module mrs_guard_chk #(
    parameter int TMRD     = 4,
    parameter int TMOD     = 12,
    parameter int TMRSPDEN = 10
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [2:0] cmd_code,
    input logic [1:0] cmd_sel,
    input logic       dll_bit,
    input logic       banks_idle,
    input logic       prech_met,
    input logic       burst_busy,
    input logic       cke,
    input logic       out_valid,
    input logic       viol,
    input logic       mr0_dll
);
    logic [15:0] since;
    logic        fire, mrs_fire, dll_wr;

    assign fire     = cmd_valid && cmd_ready;
    assign mrs_fire = fire && (cmd_code == 3'd2);
    assign dll_wr   = mrs_fire && (cmd_sel == 2'd0) && dll_bit;

    always_ff @(posedge clk) begin
        if (rst)                 since <= 16'hFFFF;
        else if (mrs_fire)       since <= 16'd1;
        else if (since != 16'hFFFF) since <= since + 16'd1;
    end

    AST_MRS_PRECOND: assert property (@(posedge clk) disable iff (rst)
        mrs_fire |-> (banks_idle && prech_met && !burst_busy)); // R2
    AST_MRS_SPACING: assert property (@(posedge clk) disable iff (rst)
        mrs_fire |-> (since >= 16'(TMRD))); // R3
    AST_UPDATE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_code >= 3'd3) |-> (since >= 16'(TMOD))); // R4
    AST_DLL_SELFCLR: assert property (@(posedge clk) disable iff (rst)
        mr0_dll |=> (!mr0_dll || $past(dll_wr))); // R6
    AST_CKE_AT_WRITE: assert property (@(posedge clk) disable iff (rst)
        mrs_fire |-> cke); // R8
    AST_CKE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (since < 16'(TMRSPDEN)) |-> cke); // R8
    AST_DROP: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> !out_valid); // R11
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol); // R11
endmodule

bind mrs_guard mrs_guard_chk #(
    .TMRD     (TMRD),
    .TMOD     (TMOD),
    .TMRSPDEN (TMRSPDEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_code   (cmd_code),
    .cmd_sel    (cmd_sel),
    .dll_bit    (cmd_val[8]),
    .banks_idle (banks_idle),
    .prech_met  (prech_met),
    .burst_busy (burst_busy),
    .cke        (cke),
    .out_valid  (out_valid),
    .viol       (viol),
    .mr0_dll    (mr_shadow[8])
);

// File: tb/mrs_guard_test.sv
module mrs_guard_test;
    import mrs_guard_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TMRD = 4, TMOD = 12, TMRSPDEN = 10, TXPDLL = 24, TDLLK = 512;

    // row: [7:5] code, [4] banks_idle, [3] prech_met, [2] burst_busy, [1] expected ready
    localparam int NV = 8;
    localparam logic [7:0] VEC [NV] = '{
        {3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_ready;
    logic [2:0] cmd_code = 3'd0;
    logic [1:0] cmd_sel = 2'd0;
    logic [13:0] cmd_val = '0;
    logic banks_idle = 1'b1, prech_met = 1'b1, burst_busy = 1'b0, pd_req = 1'b0;
    logic cke, out_valid, viol;
    logic [2:0] out_code, viol_cause;
    logic [1:0] out_sel;
    logic [13:0] out_val;
    logic [55:0] mr_shadow;

    int checks = 0, errors = 0;

    mrs_guard #(.TMRD(TMRD), .TMOD(TMOD), .TMRSPDEN(TMRSPDEN), .TXPDLL(TXPDLL), .TDLLK(TDLLK)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_sel(cmd_sel), .cmd_val(cmd_val),
        .banks_idle(banks_idle), .prech_met(prech_met), .burst_busy(burst_busy),
        .pd_req(pd_req), .cke(cke), .out_valid(out_valid), .out_code(out_code),
        .out_sel(out_sel), .out_val(out_val), .mr_shadow(mr_shadow),
        .viol(viol), .viol_cause(viol_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Presents a command for one cycle T; returns at the falling edge of T+1.
    task automatic fire(input logic [2:0] c, input logic [1:0] s, input logic [13:0] v);
        @(negedge clk);
        cmd_code = c; cmd_sel = s; cmd_val = v; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
    endtask

    task automatic count_blocked(input logic [2:0] c, output int n);
        n = 0;
        cmd_code = c;
        #1;
        while (!cmd_ready && n < 2000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic count_cke_high(output int n);
        n = 0;
        while (cke && n < 2000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R7: reset state
        check("R7 shadow after reset", 32'(mr_shadow == '0), 32'd1);
        check("R7 viol after reset", {31'd0, viol}, 32'd0);
        check("R7 out_valid after reset", {31'd0, out_valid}, 32'd0);
        check("R8 cke idle", {31'd0, cke}, 32'd1);

        // R2 / R4: vector table of readiness against bank status
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            cmd_code   = VEC[k][7:5];
            banks_idle = VEC[k][4];
            prech_met  = VEC[k][3];
            burst_busy = VEC[k][2];
            #1;
            check($sformatf("R2 table row %0d", k), {31'd0, cmd_ready}, {31'd0, VEC[k][1]});
        end
        @(negedge clk);
        banks_idle = 1'b1; prech_met = 1'b1; burst_busy = 1'b0;

        // R1 / R5 / R3: forwarding, shadow update, write spacing
        fire(3'd2, 2'd1, 14'h0123);
        check("R1 out_valid", {31'd0, out_valid}, 32'd1);
        check("R1 out_code", {29'd0, out_code}, 32'd2);
        check("R1 out_sel", {30'd0, out_sel}, 32'd1);
        check("R1 out_val", {18'd0, out_val}, 32'h0123);
        check("R5 shadow reg1", {18'd0, mr_shadow[14 +: 14]}, 32'h0123);
        count_blocked(3'd2, n);
        check("R3 write spacing blocked cycles", n, TMRD - 1);

        // R4: update delay for ordinary commands
        idle(30);
        fire(3'd2, 2'd2, 14'h0044);
        count_blocked(3'd3, n);
        check("R4 update delay blocked cycles", n, TMOD - 1);

        // R4: no-op exempt inside the window
        idle(30);
        fire(3'd2, 2'd1, 14'h0100);
        cmd_code = 3'd0; #1;
        check("R4 nop ready in window", {31'd0, cmd_ready}, 32'd1);
        fire(3'd0, 2'd0, 14'h0);
        check("R4 nop forwarded", {28'd0, out_valid, out_code}, 32'h8);
        cmd_code = 3'd1; #1;
        check("R4 deselect ready in window", {31'd0, cmd_ready}, 32'd1);

        // R9: latency change versus unchanged latency
        idle(30);
        fire(3'd2, 2'd0, 14'h0010);
        count_blocked(3'd4, n);
        check("R9 latency change blocked cycles", n, TXPDLL - 1);
        idle(30);
        fire(3'd2, 2'd0, 14'h0810);
        count_blocked(3'd4, n);
        check("R9 unchanged latency blocked cycles", n, TMOD - 1);

        // R6 / R10: self-clearing DLL reset and lock wait
        idle(30);
        fire(3'd2, 2'd0, 14'h0910);
        check("R6 bit8 at T+1", {18'd0, mr_shadow[13:0]}, 32'h0910);
        @(negedge clk); #1;
        check("R6 bit8 at T+2", {18'd0, mr_shadow[13:0]}, 32'h0810);
        count_blocked(3'd3, n);
        check("R10 dll lock blocked cycles from T+2", n, TDLLK - 2);

        // R8: clock enable hold against power-down request
        idle(30);
        pd_req = 1'b1; #1;
        check("R8 cke low outside window", {31'd0, cke}, 32'd0);
        fire(3'd2, 2'd3, 14'h0abc);
        check("R5 shadow reg3", {18'd0, mr_shadow[42 +: 14]}, 32'h0abc);
        count_cke_high(n);
        check("R8 cke held cycles after write", n, TMRSPDEN - 1);
        pd_req = 1'b0;

        // R11: violation drop, sticky flag, first cause kept
        idle(30);
        fire(3'd2, 2'd2, 14'h0055);
        fire(3'd3, 2'd0, 14'h0);
        check("R11 dropped command", {31'd0, out_valid}, 32'd0);
        check("R11 viol set", {31'd0, viol}, 32'd1);
        check("R11 cause update window", {29'd0, viol_cause}, 32'd5);
        idle(30);
        banks_idle = 1'b0;
        fire(3'd2, 2'd2, 14'h1111);
        banks_idle = 1'b1;
        check("R11 blocked write dropped", {31'd0, out_valid}, 32'd0);
        check("R11 shadow untouched", {18'd0, mr_shadow[28 +: 14]}, 32'h0055);
        check("R11 viol sticky", {31'd0, viol}, 32'd1);
        check("R11 first cause kept", {29'd0, viol_cause}, 32'd5);

        // R7: reset clears shadow and violation state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check("R7 shadow cleared", 32'(mr_shadow == '0), 32'd1);
        check("R7 viol cleared", {28'd0, viol, viol_cause}, 32'd0);
        cmd_code = 3'd3; #1;
        check("R7 timers cleared", {31'd0, cmd_ready}, 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule